// File: doc/BRIEF.md
# CAN Frame Format Checker

This block follows a CAN bit stream one bit at a time. The stream has already been sampled and destuffed upstream. Each bit comes with a one-cycle valid strobe. The block tracks where each bit sits inside a standard-format data frame, and it pulses a field marker with a field code whenever a field finishes.

It checks the bits whose level is fixed by the frame format. Each broken rule raises its own one-cycle warning line. A sticky error flag summarises the frame. Parsing carries on after any warning.

The identifier, remote-request bit, length code, CRC field and acknowledge result are captured and held on outputs until the next frame starts. The CRC field is only captured and is not checked. Every bit position after the length code is computed from the length code as received, including codes above eight.

Top module: `can_frame_checker`

## Requirements
- R1: While `rst_ni` is low, every output is zero and the parser is idle. Captured fields and the sticky flag are cleared.
- R2: When idle with `SOF_ANY_START`=0, a recessive (1) valid bit is ignored: no marker, no warning, no frame start. A dominant (0) valid bit is taken as bit 0, the start of frame.
- R3: With `SOF_ANY_START`=1, any valid bit starts a frame when idle. If that start bit is recessive, the SOF marker is still issued and `warn_o[0]` pulses.
- R4: Bits 1..11 are the identifier, MSB first, and appear on `ident_o`. Bit 12 is captured on `rtr_o`. When bit 11 arrives, `warn_o[1]` pulses if identifier bits 10..4 are all 1.
- R5: If bit 13 (the format bit) is recessive, `warn_o[2]` pulses and parsing continues as a standard frame.
- R6: Bits 15..18 are the length code, MSB first, on `dlc_o`. When bit 18 arrives, `warn_o[3]` pulses if the code is above 8. The data field spans code*8 bits in every case, so the last data bit index is L = 18 + code*8.
- R7: Bits L+1..L+15 are shifted MSB first into `crc_o` without any check.
- R8: The bit at L+16 is the CRC delimiter. If it is dominant, `warn_o[4]` pulses.
- R9: The bit at L+17 is the acknowledge slot. `ack_o` becomes 1 if it is dominant and 0 if it is recessive.
- R10: The bit at L+18 is the acknowledge delimiter. If it is dominant, `warn_o[5]` pulses.
- R11: Bits L+19..L+25 are end of frame. When bit L+25 arrives, `warn_o[6]` pulses if any of those seven bits was dominant, `frame_done_o` pulses, and the parser returns to idle.
- R12: Markers, warnings and `frame_done_o` are registered. Each is high for exactly the one cycle after the clock edge that samples the bit. Field codes on `field_id_o`: 0 SOF (bit 0), 1 identifier (bit 11), 2 RTR (bit 12), 3 format bit (bit 13), 4 reserved bit (bit 14), 5 length (bit 18), 6 data (bit L, only when code > 0), 7 CRC (L+15), 8 CRC delimiter (L+16), 9 ACK slot (L+17), 10 ACK delimiter (L+18), 11 end of frame (L+25).
- R13: `frame_err_o` goes high with any warning and stays high until the next frame start. It is then cleared, unless the start bit itself warns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Strobe: `bit_i` holds a new bit |
| bit_i | input | 1 | Bus level, 0 dominant, 1 recessive |
| field_done_o | output | 1 | Field-complete pulse |
| field_id_o | output | 4 | Code of the completed field |
| warn_o | output | 7 | One-cycle rule-violation pulses, one line per rule |
| frame_done_o | output | 1 | Pulse on the last end-of-frame bit |
| frame_err_o | output | 1 | Sticky per-frame violation flag |
| ident_o | output | 11 | Captured identifier |
| rtr_o | output | 1 | Captured remote-request bit |
| dlc_o | output | 4 | Captured length code |
| crc_o | output | 15 | Captured CRC field |
| ack_o | output | 1 | Acknowledge slot was dominant |

## Verification
The bench targets the length-dependent offsets with codes 0, 8 and 15.

- With code 0 there is no data marker, and the CRC starts right after bit 18. A design that emitted a data marker anyway, or clamped the length at 8, would place every later marker and the frame end at the wrong bit.
- Identifiers on either side of the 0x7F0 boundary (0x7F0 and 0x7EF) show whether the all-recessive rule looks at the right seven bits.
- End-of-frame faults are placed at random positions within the seven bits, so a check that only looked at the last bit would miss most of them.
- Recessive idle bits, and a recessive start bit in the permissive start mode, show whether frame start is gated correctly and whether the sticky flag clears at the start of a new frame.

// File: rtl/can_fchk_pkg.sv
package can_fchk_pkg;
  localparam int ID_W      = 11;
  localparam int DLC_W     = 4;
  localparam int CRC_W     = 15;
  localparam int EOF_LEN   = 7;
  localparam int ID_RULE_W = 7;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 8;

  localparam int POS_ID_END  = ID_W;
  localparam int POS_RTR     = ID_W + 1;
  localparam int POS_IDE     = ID_W + 2;
  localparam int POS_R0      = ID_W + 3;
  localparam int POS_DLC_END = POS_R0 + DLC_W;
  localparam int MAX_LAST    = POS_DLC_END + ((1 << DLC_W) - 1) * BYTE_W;

  localparam int OFS_CRC_END = CRC_W;
  localparam int OFS_CRC_DEL = CRC_W + 1;
  localparam int OFS_ACK     = CRC_W + 2;
  localparam int OFS_ACK_DEL = CRC_W + 3;
  localparam int OFS_EOF_BEG = CRC_W + 4;
  localparam int OFS_EOF_END = CRC_W + 3 + EOF_LEN;

  localparam int MAX_POS = MAX_LAST + OFS_EOF_END;
  localparam int POS_W   = $clog2(MAX_POS + 1);

  localparam int NUM_WARN = 7;
  localparam int W_SOF  = 0;
  localparam int W_ID   = 1;
  localparam int W_IDE  = 2;
  localparam int W_DLC  = 3;
  localparam int W_CRCD = 4;
  localparam int W_ACKD = 5;
  localparam int W_EOF  = 6;

  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic [3:0] {
    FLD_SOF  = 4'd0,
    FLD_ID   = 4'd1,
    FLD_RTR  = 4'd2,
    FLD_IDE  = 4'd3,
    FLD_R0   = 4'd4,
    FLD_DLC  = 4'd5,
    FLD_DATA = 4'd6,
    FLD_CRC  = 4'd7,
    FLD_CRCD = 4'd8,
    FLD_ACK  = 4'd9,
    FLD_ACKD = 4'd10,
    FLD_EOF  = 4'd11
  } fld_e;
endpackage

// File: rtl/can_fchk_tracker.sv
module can_fchk_tracker
  import can_fchk_pkg::*;
#(
  parameter bit SOF_ANY_START = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             bit_i,
  input  logic [DLC_W-2:0] dlc_hi_i,
  output logic             take_o,
  output pos_t             idx_o,
  output pos_t             last_o
);
  logic busy_q;
  pos_t pos_q, last_q;
  logic tail, at_end;

  always_comb begin
    idx_o  = busy_q ? pos_q : '0;
    take_o = valid_i && (busy_q || !bit_i || SOF_ANY_START);
    tail   = idx_o > pos_t'(POS_DLC_END);
    at_end = tail && (idx_o == last_q + pos_t'(OFS_EOF_END));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      last_q <= '0;
    end else if (take_o) begin
      if (at_end) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
      end else begin
        busy_q <= 1'b1;
        pos_q  <= idx_o + pos_t'(1);
      end
      // last data index follows the raw length code, even above eight
      if (idx_o == pos_t'(POS_DLC_END))
        last_q <= pos_t'(POS_DLC_END) + pos_t'({dlc_hi_i, bit_i}) * pos_t'(BYTE_W);
    end
  end

  assign last_o = last_q;

  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (pos_q <= pos_t'(MAX_POS))) else $error("position overrun"); // R11
  AST_IDLE_RECESSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && valid_i && bit_i && !SOF_ANY_START) |=> !busy_q) else $error("recessive start"); // R2
endmodule

// File: rtl/can_fchk_capture.sv
module can_fchk_capture
  import can_fchk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             bit_i,
  input  pos_t             idx_i,
  input  pos_t             last_i,
  output logic [ID_W-1:0]  ident_o,
  output logic             rtr_o,
  output logic [DLC_W-1:0] dlc_o,
  output logic [CRC_W-1:0] crc_o,
  output logic             ack_o,
  output logic             eof_ok_o
);
  logic tail, in_id, in_dlc, in_crc, in_eof;

  always_comb begin
    tail   = idx_i > pos_t'(POS_DLC_END);
    in_id  = (idx_i >= pos_t'(1)) && (idx_i <= pos_t'(POS_ID_END));
    in_dlc = (idx_i > pos_t'(POS_R0)) && (idx_i <= pos_t'(POS_DLC_END));
    in_crc = tail && (idx_i > last_i) && (idx_i <= last_i + pos_t'(OFS_CRC_END));
    in_eof = tail && (idx_i >= last_i + pos_t'(OFS_EOF_BEG));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ident_o  <= '0;
      rtr_o    <= 1'b0;
      dlc_o    <= '0;
      crc_o    <= '0;
      ack_o    <= 1'b0;
      eof_ok_o <= 1'b1;
    end else if (take_i) begin
      if (idx_i == '0) begin
        ident_o  <= '0;
        rtr_o    <= 1'b0;
        dlc_o    <= '0;
        crc_o    <= '0;
        ack_o    <= 1'b0;
        eof_ok_o <= 1'b1;
      end
      if (in_id)  ident_o <= {ident_o[ID_W-2:0], bit_i};
      if (idx_i == pos_t'(POS_RTR)) rtr_o <= bit_i;
      if (in_dlc) dlc_o <= {dlc_o[DLC_W-2:0], bit_i};
      if (in_crc) crc_o <= {crc_o[CRC_W-2:0], bit_i};
      if (tail && (idx_i == last_i + pos_t'(OFS_ACK))) ack_o <= !bit_i;
      if (in_eof) eof_ok_o <= eof_ok_o & bit_i;
    end
  end

  AST_ID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i || idx_i > pos_t'(POS_ID_END)) && idx_i != '0 |=> $stable(ident_o)) else $error("ident moved"); // R4
endmodule

// File: rtl/can_fchk_rules.sv
module can_fchk_rules
  import can_fchk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take_i,
  input  logic                bit_i,
  input  pos_t                idx_i,
  input  pos_t                last_i,
  input  logic [ID_W-1:0]     ident_i,
  input  logic [DLC_W-2:0]    dlc_hi_i,
  input  logic                eof_ok_i,
  output logic [NUM_WARN-1:0] warn_o,
  output logic                field_done_o,
  output fld_e                field_id_o,
  output logic                frame_done_o,
  output logic                frame_err_o
);
  logic [NUM_WARN-1:0] warn_now;
  logic [ID_W-1:0]     id_full;
  logic [DLC_W-1:0]    dlc_full;
  logic                tail, start, mark_v, done_now;
  fld_e                mark_c;

  always_comb begin
    tail     = idx_i > pos_t'(POS_DLC_END);
    start    = take_i && (idx_i == '0);
    id_full  = {ident_i[ID_W-2:0], bit_i};
    dlc_full = {dlc_hi_i, bit_i};
    warn_now = '0;
    warn_now[W_SOF]  = start && bit_i;
    warn_now[W_ID]   = take_i && (idx_i == pos_t'(POS_ID_END)) && (&id_full[ID_W-1 -: ID_RULE_W]);
    warn_now[W_IDE]  = take_i && (idx_i == pos_t'(POS_IDE)) && bit_i;
    warn_now[W_DLC]  = take_i && (idx_i == pos_t'(POS_DLC_END)) && (dlc_full > DLC_W'(MAX_BYTES));
    warn_now[W_CRCD] = take_i && tail && (idx_i == last_i + pos_t'(OFS_CRC_DEL)) && !bit_i;
    warn_now[W_ACKD] = take_i && tail && (idx_i == last_i + pos_t'(OFS_ACK_DEL)) && !bit_i;
    done_now         = take_i && tail && (idx_i == last_i + pos_t'(OFS_EOF_END));
    warn_now[W_EOF]  = done_now && !(eof_ok_i && bit_i);

    mark_v = take_i;
    mark_c = FLD_SOF;
    if (idx_i == '0)                                   mark_c = FLD_SOF;
    else if (idx_i == pos_t'(POS_ID_END))              mark_c = FLD_ID;
    else if (idx_i == pos_t'(POS_RTR))                 mark_c = FLD_RTR;
    else if (idx_i == pos_t'(POS_IDE))                 mark_c = FLD_IDE;
    else if (idx_i == pos_t'(POS_R0))                  mark_c = FLD_R0;
    else if (idx_i == pos_t'(POS_DLC_END))             mark_c = FLD_DLC;
    else if (tail && idx_i == last_i)                  mark_c = FLD_DATA;
    else if (tail && idx_i == last_i + pos_t'(OFS_CRC_END)) mark_c = FLD_CRC;
    else if (tail && idx_i == last_i + pos_t'(OFS_CRC_DEL)) mark_c = FLD_CRCD;
    else if (tail && idx_i == last_i + pos_t'(OFS_ACK))     mark_c = FLD_ACK;
    else if (tail && idx_i == last_i + pos_t'(OFS_ACK_DEL)) mark_c = FLD_ACKD;
    else if (done_now)                                 mark_c = FLD_EOF;
    else                                               mark_v = 1'b0;
  end

  for (genvar g = 0; g < NUM_WARN; g++) begin : g_warn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) warn_o[g] <= 1'b0;
      else         warn_o[g] <= warn_now[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_done_o <= 1'b0;
      field_id_o   <= FLD_SOF;
      frame_done_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      field_done_o <= mark_v;
      field_id_o   <= mark_v ? mark_c : FLD_SOF;
      frame_done_o <= done_now;
      if (start) frame_err_o <= |warn_now;
      else       frame_err_o <= frame_err_o | (|warn_now);
    end
  end

  AST_WARN_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|warn_o) |-> $past(take_i)) else $error("warning without bit"); // R12
  AST_DONE_IS_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (field_done_o && field_id_o == FLD_EOF)) else $error("done w/o eof"); // R11
  AST_ERR_ON_WARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|warn_o) |-> frame_err_o) else $error("warn not sticky"); // R13
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o && !start) |=> frame_err_o) else $error("err dropped"); // R13
endmodule

// File: rtl/can_frame_checker.sv
module can_frame_checker
  import can_fchk_pkg::*;
#(
  parameter bit SOF_ANY_START = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_valid_i,
  input  logic                bit_i,
  output logic                field_done_o,
  output logic [3:0]          field_id_o,
  output logic [NUM_WARN-1:0] warn_o,
  output logic                frame_done_o,
  output logic                frame_err_o,
  output logic [ID_W-1:0]     ident_o,
  output logic                rtr_o,
  output logic [DLC_W-1:0]    dlc_o,
  output logic [CRC_W-1:0]    crc_o,
  output logic                ack_o
);
  logic take, eof_ok;
  pos_t idx, last;
  fld_e fld;

  can_fchk_tracker #(.SOF_ANY_START(SOF_ANY_START)) u_tracker (
    .clk_i, .rst_ni,
    .valid_i  (bit_valid_i),
    .bit_i,
    .dlc_hi_i (dlc_o[DLC_W-2:0]),
    .take_o   (take),
    .idx_o    (idx),
    .last_o   (last)
  );

  can_fchk_capture u_capture (
    .clk_i, .rst_ni,
    .take_i   (take),
    .bit_i,
    .idx_i    (idx),
    .last_i   (last),
    .ident_o, .rtr_o, .dlc_o, .crc_o, .ack_o,
    .eof_ok_o (eof_ok)
  );

  can_fchk_rules u_rules (
    .clk_i, .rst_ni,
    .take_i       (take),
    .bit_i,
    .idx_i        (idx),
    .last_i       (last),
    .ident_i      (ident_o),
    .dlc_hi_i     (dlc_o[DLC_W-2:0]),
    .eof_ok_i     (eof_ok),
    .warn_o,
    .field_done_o,
    .field_id_o   (fld),
    .frame_done_o,
    .frame_err_o
  );

  assign field_id_o = fld;

  AST_DLC_WARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o[W_DLC] |-> (dlc_o > DLC_W'(MAX_BYTES))) else $error("dlc warn mismatch"); // R6
  AST_ACK_AT_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_done_o && field_id_o == 4'd9) |-> (ack_o == !$past(bit_i))) else $error("ack capture"); // R9
endmodule

// File: tb/can_frame_checker_tb_top.sv
`timescale 1ns/1ps
module can_frame_checker_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic va = 1'b0, ba = 1'b1, vb = 1'b0, bb = 1'b1;
  logic fd, fe, ack, rtr, fdn;
  logic [3:0] fid, dlc;
  logic [6:0] warn;
  logic [10:0] ident;
  logic [14:0] crc;
  logic b_fd, b_fe, b_ack, b_rtr, b_fdn;
  logic [3:0] b_fid, b_dlc;
  logic [6:0] b_warn;
  logic [10:0] b_ident;
  logic [14:0] b_crc;

  can_frame_checker dut_i (
    .clk_i(clk), .rst_ni, .bit_valid_i(va), .bit_i(ba),
    .field_done_o(fd), .field_id_o(fid), .warn_o(warn), .frame_done_o(fdn),
    .frame_err_o(fe), .ident_o(ident), .rtr_o(rtr), .dlc_o(dlc), .crc_o(crc), .ack_o(ack));

  can_frame_checker #(.SOF_ANY_START(1'b1)) dut_any_i (
    .clk_i(clk), .rst_ni, .bit_valid_i(vb), .bit_i(bb),
    .field_done_o(b_fd), .field_id_o(b_fid), .warn_o(b_warn), .frame_done_o(b_fdn),
    .frame_err_o(b_fe), .ident_o(b_ident), .rtr_o(b_rtr), .dlc_o(b_dlc), .crc_o(b_crc), .ack_o(b_ack));

  int n_chk = 0, n_bad = 0;
  logic fb [0:199];
  int flen, f_last;
  logic [10:0] f_id;
  logic f_rtr, f_ack;
  logic [3:0] f_dlc;
  logic [14:0] f_crc;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [10:0] id, input logic rtr_b, input logic ide,
                       input logic [3:0] d, input logic crcd_bad, input logic ackd_bad,
                       input logic eof_bad, input logic ack_b);
    for (int i = 0; i < 200; i++) fb[i] = 1'b1;
    f_id = id; f_rtr = rtr_b; f_dlc = d; f_ack = ack_b;
    f_crc = 15'($urandom);
    fb[0] = 1'b0;
    for (int i = 0; i < 11; i++) fb[1+i] = id[10-i];
    fb[12] = rtr_b; fb[13] = ide; fb[14] = 1'b0;
    for (int i = 0; i < 4; i++) fb[15+i] = d[3-i];
    f_last = 18 + int'(d) * 8;
    for (int i = 19; i <= f_last; i++) fb[i] = 1'($urandom);
    for (int i = 0; i < 15; i++) fb[f_last+1+i] = f_crc[14-i];
    fb[f_last+16] = !crcd_bad;
    fb[f_last+17] = !ack_b;
    fb[f_last+18] = !ackd_bad;
    if (eof_bad) fb[f_last+19+int'($urandom % 7)] = 1'b0;
    flen = f_last + 26;
  endtask

  function automatic logic [4:0] exp_mark(int k);
    if (k == 0) return {1'b1, 4'd0};
    if (k == 11) return {1'b1, 4'd1};
    if (k == 12) return {1'b1, 4'd2};
    if (k == 13) return {1'b1, 4'd3};
    if (k == 14) return {1'b1, 4'd4};
    if (k == 18) return {1'b1, 4'd5};
    if (k == f_last && f_dlc != 0) return {1'b1, 4'd6};
    if (k == f_last + 15) return {1'b1, 4'd7};
    if (k == f_last + 16) return {1'b1, 4'd8};
    if (k == f_last + 17) return {1'b1, 4'd9};
    if (k == f_last + 18) return {1'b1, 4'd10};
    if (k == f_last + 25) return {1'b1, 4'd11};
    return 5'd0;
  endfunction

  function automatic logic [6:0] exp_warn(int k);
    logic [6:0] w = '0;
    logic all1;
    if (k == 0) w[0] = fb[0];
    if (k == 11) begin
      all1 = 1'b1;
      for (int i = 1; i <= 7; i++) all1 &= fb[i];
      w[1] = all1;
    end
    if (k == 13) w[2] = fb[13];
    if (k == 18) w[3] = (f_dlc > 4'd8);
    if (k == f_last + 16) w[4] = !fb[k];
    if (k == f_last + 18) w[5] = !fb[k];
    if (k == f_last + 25) begin
      all1 = 1'b1;
      for (int i = f_last + 19; i <= f_last + 25; i++) all1 &= fb[i];
      w[6] = !all1;
    end
    return w;
  endfunction

  task automatic drive(input logic b);
    @(negedge clk); va = 1'b1; ba = b;
    @(negedge clk); va = 1'b0; ba = 1'b1;
  endtask

  task automatic drive_any(input logic b);
    @(negedge clk); vb = 1'b1; bb = b;
    @(negedge clk); vb = 1'b0; bb = 1'b1;
  endtask

  task automatic send_frame();
    logic any_w = 1'b0;
    for (int k = 0; k < flen; k++) begin
      drive(fb[k]);
      chk("R12", $sformatf("marker bit %0d", k), {fd, fid}, exp_mark(k));
      chk("R4/R5/R6/R8/R10/R11", $sformatf("warn bit %0d", k), warn, exp_warn(k));
      chk("R11", $sformatf("done bit %0d", k), fdn, k == flen - 1);
      any_w |= (exp_warn(k) != 0);
    end
    chk("R4", "ident", ident, f_id);
    chk("R4", "rtr", rtr, f_rtr);
    chk("R6", "dlc", dlc, f_dlc);
    chk("R7", "crc", crc, f_crc);
    chk("R9", "ack", ack, f_ack);
    chk("R13", "frame_err", fe, any_w);
  endtask

  task automatic idle_bits(int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b1);
      chk("R2", "idle marker", {fd, warn, fdn}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {fd, fid, warn, fdn, fe, ident, rtr, dlc, crc, ack}, 0);
    rst_ni = 1'b1;
    idle_bits(3);

    build(11'h7f0, 1'b0, 1'b0, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1); send_frame();   // R4 id rule hit
    build(11'h7ef, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0); send_frame();   // R6 no data field
    idle_bits(2);                                                              // R13 err from prior frame clears on start
    build(11'h123, 1'b0, 1'b1, 4'd8, 1'b1, 1'b0, 1'b0, 1'b1); send_frame();   // R5 R8
    build(11'h555, 1'b0, 1'b0, 4'd15, 1'b0, 1'b1, 1'b1, 1'b1); send_frame();  // R6 R10 R11
    build(11'h001, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1); send_frame();   // clean

    for (int n = 0; n < 40; n++) begin
      logic [10:0] id = 11'($urandom);
      logic [3:0] d;
      if ($urandom % 4 == 0) id |= 11'h7f0;
      d = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
      build(id, 1'($urandom), ($urandom % 8 == 0), d, ($urandom % 8 == 0),
            ($urandom % 8 == 0), ($urandom % 6 == 0), 1'($urandom));
      send_frame();
      if ($urandom % 3 == 0) idle_bits(1);
    end

    // R1: reset in the middle of a frame
    build(11'h2aa, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 30; k++) drive(fb[k]);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", "mid-frame reset", {fd, warn, fdn, fe, ident, rtr, dlc, crc, ack}, 0);
    rst_ni = 1'b1;
    idle_bits(2);
    build(11'h3c3, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0); send_frame();

    // R3: permissive start, recessive start bit
    build(11'h0f0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    fb[0] = 1'b1;
    for (int k = 0; k < flen; k++) begin
      drive_any(fb[k]);
      if (k == 0) begin
        chk("R3", "sof marker", {b_fd, b_fid}, {1'b1, 4'd0});
        chk("R3", "sof warn", b_warn, 7'd1);
      end
    end
    chk("R3", "frame done", b_fdn, 1'b1);
    chk("R3", "frame err", b_fe, 1'b1);
    chk("R3", "ident", b_ident, 11'h0f0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule